// File: doc/BRIEF.md
# Triple-Lane Two-Round Agreement Fabric

This block lets three redundant processing lanes settle on one common data word, even when one unit misbehaves. Each lane offers a word. In a first round the words are sent into three relay units. In a second round every relay sends its result back to all three lanes, and each lane takes a bitwise 2-of-3 majority of the three copies it receives. A fault can sit in a lane or in a relay, but not in both, so one of the two rounds is always free of errors. Because of that second round, three lanes are enough and no received copy is ever thrown away.

There are two ways to run the first round. In single-source mode, one chosen lane sends its own word, one copy to each relay, and each relay passes its copy on unchanged. In all-source mode, every lane sends to every relay, and each relay votes over the three words before it passes the result on. Each relay adds a fixed pipeline delay, so all copies of a round arrive in the same cycle. A start pulse launches a transfer, and a done pulse marks the cycle in which the voted outputs are new. Fault-injection inputs can make any lane or any relay send arbitrary, destination-specific words. The bench uses them to model inconsistent units.

Top module: `agree_fabric`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done`, every `lane_dout` word and every `lane_mismatch` bit are 0.
- R2: In all-source mode (`mode`=1) with no injection and identical lane words, every lane outputs that word.
- R3: In single-source mode (`mode`=0) with no injection, every lane outputs the word of the source lane. The source lane is chosen by `src_sel`: 0, 1 or 2 pick that lane, and 3 picks lane 2. The words of the other lanes have no effect.
- R4: In all-source mode each relay forms the bitwise majority of the three lane words. An output bit is 1 when at least two of its three inputs are 1. For example, lane words F0, CC, AA give E8 on every lane.
- R5: If `start` is sampled high at clock edge 0, `done` is high for exactly one cycle, right after edge 2·(DLY+1)−1. The new outputs appear on that same edge. `lane_dout` and `lane_mismatch` change only when `done` rises.
- R6: In single-source mode, if the source lane sends different words to the three relays, all lanes still output the same word: the bitwise majority of the three words it sent.
- R7: If only one relay is faulty and sends any words, per destination, while the lanes feed it correct data, every lane outputs the correct agreed word.
- R8: `lane_mismatch[j]` is 1 exactly when the three copies that lane j received in round 1 are not all equal. The flag never changes the voted word.
- R9: In all-source mode, if one lane sends different words to different relays, every lane outputs the same word.
- R10: `mode`, `src_sel`, `lane_din` and the lane injection inputs are sampled on the `start` edge. Changing them during the transfer has no effect on its result. Relay injection is applied at the end of round 1 and must be held constant during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches round 0 with the sampled inputs |
| mode | input | 1 | 0 = single source, 1 = all lanes send |
| src_sel | input | 2 | Source lane in single-source mode (3 selects lane 2) |
| lane_din | input | 3*W | Lane words; lane j at bits [j*W +: W] |
| lane_inj_en | input | 3 | Per-lane override of the round-0 words it sends |
| lane_inj_val | input | 9*W | Override from lane l to relay i at bits [(l*3+i)*W +: W] |
| relay_inj_en | input | 3 | Per-relay override of its round-1 words |
| relay_inj_val | input | 9*W | Override from relay i to lane j at bits [(i*3+j)*W +: W] |
| lane_dout | output | 3*W | Voted word of each lane; lane j at bits [j*W +: W] |
| lane_mismatch | output | 3 | Lane saw three copies that were not all equal |
| done | output | 1 | One-cycle pulse when the new results are on the outputs |

## Verification
Fault-free transfers in both modes, with deliberately different words per lane, show whether the source selection works and whether the relays really vote. The words F0/CC/AA, which differ bit by bit, expose a majority that works per word instead of per bit. A source that sends three different words, and a relay that sends a different word to each lane, test the two fault classes. Those two cases separate a design that reaches agreement from one that only happens to be right when its inputs are consistent. Seeded random mixes of mode, source, data and a single faulty unit then cover the combinations, and each result is compared with a bench model built only from the requirements.

// File: rtl/agree_pkg.sv
package agree_pkg;
  localparam int N_UNITS = 3;

  function automatic logic [63:0] maj3(input logic [63:0] a, input logic [63:0] b,
                                       input logic [63:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic all_same(input logic [63:0] a, input logic [63:0] b,
                                    input logic [63:0] c);
    return (a == b) && (b == c);
  endfunction
endpackage

// File: rtl/agree_dly.sv
module agree_dly #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         vout,
  output logic [W-1:0] dout
);
  logic [W-1:0]     dq [DEPTH];
  logic [DEPTH-1:0] vq;

  // data path without reset so it can map to shift-register primitives
  always_ff @(posedge clk) begin
    dq[0] <= din;
    for (int k = 1; k < DEPTH; k++) dq[k] <= dq[k-1];
  end

  generate
    if (DEPTH == 1) begin : g_v1
      always_ff @(posedge clk) begin
        if (rst) vq <= '0;
        else     vq <= vin;
      end
    end else begin : g_vn
      always_ff @(posedge clk) begin
        if (rst) vq <= '0;
        else     vq <= {vq[DEPTH-2:0], vin};
      end
    end
  endgenerate

  assign vout = vq[DEPTH-1];
  assign dout = dq[DEPTH-1];
endmodule

// File: rtl/agree_relay.sv
module agree_relay #(
  parameter int W   = 8,
  parameter int DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         vout,
  output logic [W-1:0] dout
);
  import agree_pkg::*;

  logic [63:0]  m64;
  logic [W-1:0] voted;

  always_comb begin
    m64   = maj3(64'(a), 64'(b), 64'(c));
    voted = m64[W-1:0];
  end

  agree_dly #(.W(W), .DEPTH(DLY)) dly_i (
    .clk(clk), .rst(rst), .vin(vin), .din(voted), .vout(vout), .dout(dout)
  );
endmodule

// File: rtl/agree_lane.sv
module agree_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  output logic [W-1:0] q,
  output logic         diff
);
  import agree_pkg::*;

  logic [63:0] m64;
  logic        same;

  always_comb begin
    m64  = maj3(64'(x0), 64'(x1), 64'(x2));
    same = all_same(64'(x0), 64'(x1), 64'(x2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      diff <= 1'b0;
    end else if (load) begin
      q    <= m64[W-1:0];
      diff <= ~same;
    end
  end
endmodule

// File: rtl/agree_fabric.sv
module agree_fabric #(
  parameter int W   = 8,
  parameter int DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [1:0]       src_sel,
  input  logic [3*W-1:0]   lane_din,
  input  logic [2:0]       lane_inj_en,
  input  logic [9*W-1:0]   lane_inj_val,
  input  logic [2:0]       relay_inj_en,
  input  logic [9*W-1:0]   relay_inj_val,
  output logic [3*W-1:0]   lane_dout,
  output logic [2:0]       lane_mismatch,
  output logic             done
);
  import agree_pkg::*;

  localparam int NU = N_UNITS;
  localparam int FW = NU * NU * W;

  logic [W-1:0]  sent [NU][NU];
  logic [W-1:0]  src_word [NU];
  logic [FW-1:0] feed;
  logic          arr_v;
  logic [FW-1:0] arr_d;
  logic [NU-1:0] rel_v;
  logic [W-1:0]  rel_d [NU];
  logic [W-1:0]  recv [NU][NU];
  logic          all_v;

  // round 0: words each lane puts on its link to each relay
  always_comb begin
    for (int l = 0; l < NU; l++)
      for (int i = 0; i < NU; i++)
        sent[l][i] = lane_inj_en[l] ? lane_inj_val[(l*NU+i)*W +: W]
                                    : lane_din[l*W +: W];
    for (int i = 0; i < NU; i++) begin
      case (src_sel)
        2'd0:    src_word[i] = sent[0][i];
        2'd1:    src_word[i] = sent[1][i];
        default: src_word[i] = sent[2][i];
      endcase
    end
    // single source: the relay sees its one copy three times, so its vote passes it on
    for (int i = 0; i < NU; i++)
      for (int k = 0; k < NU; k++)
        feed[(i*NU+k)*W +: W] = mode ? sent[k][i] : src_word[i];
  end

  agree_dly #(.W(FW), .DEPTH(DLY+1)) r0_i (
    .clk(clk), .rst(rst), .vin(start), .din(feed), .vout(arr_v), .dout(arr_d)
  );

  generate
    for (genvar gi = 0; gi < NU; gi++) begin : g_relay
      agree_relay #(.W(W), .DLY(DLY)) relay_i (
        .clk(clk), .rst(rst), .vin(arr_v),
        .a(arr_d[(gi*NU+0)*W +: W]),
        .b(arr_d[(gi*NU+1)*W +: W]),
        .c(arr_d[(gi*NU+2)*W +: W]),
        .vout(rel_v[gi]), .dout(rel_d[gi])
      );
    end
  endgenerate

  // round 1: what each lane receives from each relay
  always_comb begin
    for (int i = 0; i < NU; i++)
      for (int j = 0; j < NU; j++)
        recv[i][j] = relay_inj_en[i] ? relay_inj_val[(i*NU+j)*W +: W] : rel_d[i];
  end

  assign all_v = &rel_v;

  generate
    for (genvar gj = 0; gj < NU; gj++) begin : g_lane
      agree_lane #(.W(W)) lane_i (
        .clk(clk), .rst(rst), .load(all_v),
        .x0(recv[0][gj]), .x1(recv[1][gj]), .x2(recv[2][gj]),
        .q(lane_dout[gj*W +: W]), .diff(lane_mismatch[gj])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= all_v;
  end
endmodule

// File: rtl/agree_fabric_chk.sv
module agree_fabric_chk #(
  parameter int W   = 8,
  parameter int DLY = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [2:0]     relay_inj_en,
  input logic [3*W-1:0] lane_dout,
  input logic [2:0]     lane_mismatch,
  input logic           done
);
  localparam int LAT = 2 * (DLY + 1);

  logic [LAT-1:0] start_hist;

  always_ff @(posedge clk) begin
    if (rst) start_hist <= '0;
    else     start_hist <= {start_hist[LAT-2:0], start};
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (done == 1'b0 && lane_dout == '0 && lane_mismatch == 3'b000));

  assert_done_latency_R5: assert property (@(posedge clk) disable iff (rst)
    done == start_hist[LAT-1]);

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(lane_dout) && $stable(lane_mismatch)));

  // R9: healthy relays hand every lane the same three copies
  assert_lanes_agree_R9: assert property (@(posedge clk) disable iff (rst)
    (done && relay_inj_en == 3'b000) |->
      (lane_dout[W-1:0] == lane_dout[2*W-1:W] && lane_dout[2*W-1:W] == lane_dout[3*W-1:2*W]));

  assert_flags_agree_R8: assert property (@(posedge clk) disable iff (rst)
    (done && relay_inj_en == 3'b000) |->
      (lane_mismatch == 3'b000 || lane_mismatch == 3'b111));
endmodule

bind agree_fabric agree_fabric_chk #(.W(W), .DLY(DLY)) chk_i (
  .clk(clk), .rst(rst), .start(start), .relay_inj_en(relay_inj_en),
  .lane_dout(lane_dout), .lane_mismatch(lane_mismatch), .done(done)
);

// File: tb/agree_fabric_tb_top.sv
`timescale 1ns/1ps
module agree_fabric_tb_top;
  localparam int W   = 8;
  localparam int DLY = 2;
  localparam int LAT = 2 * (DLY + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           mode = 1'b0;
  logic [1:0]     src_sel = '0;
  logic [3*W-1:0] lane_din = '0;
  logic [2:0]     lane_inj_en = '0;
  logic [9*W-1:0] lane_inj_val = '0;
  logic [2:0]     relay_inj_en = '0;
  logic [9*W-1:0] relay_inj_val = '0;
  logic [3*W-1:0] lane_dout;
  logic [2:0]     lane_mismatch;
  logic           done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  agree_fabric #(.W(W), .DLY(DLY)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .src_sel(src_sel),
    .lane_din(lane_din), .lane_inj_en(lane_inj_en), .lane_inj_val(lane_inj_val),
    .relay_inj_en(relay_inj_en), .relay_inj_val(relay_inj_val),
    .lane_dout(lane_dout), .lane_mismatch(lane_mismatch), .done(done)
  );

  function automatic logic [W-1:0] vote(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    lane_inj_en = '0; lane_inj_val = '0; relay_inj_en = '0; relay_inj_val = '0;
  endtask

  task automatic run(input string tag);
    logic [W-1:0] s [3][3];
    logic [W-1:0] iv [3];
    logic [W-1:0] y [3][3];
    logic [W-1:0] ed [3];
    logic [2:0]   em;
    int           se;
    bit           early;
    se = (src_sel == 2'd3) ? 2 : int'(src_sel);
    for (int l = 0; l < 3; l++)
      for (int i = 0; i < 3; i++)
        s[l][i] = lane_inj_en[l] ? lane_inj_val[(l*3+i)*W +: W] : lane_din[l*W +: W];
    for (int i = 0; i < 3; i++)
      iv[i] = mode ? vote(s[0][i], s[1][i], s[2][i]) : s[se][i];
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        y[i][j] = relay_inj_en[i] ? relay_inj_val[(i*3+j)*W +: W] : iv[i];
    for (int j = 0; j < 3; j++) begin
      ed[j] = vote(y[0][j], y[1][j], y[2][j]);
      em[j] = !(y[0][j] == y[1][j] && y[1][j] == y[2][j]);
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R10: sampled inputs scrambled once the start edge has passed
    lane_din = 24'($urandom); src_sel = 2'($urandom); mode = 1'($urandom);
    lane_inj_en = 3'($urandom); lane_inj_val = 72'({$urandom, $urandom, $urandom});
    early = 1'b0;
    for (int k = 1; k < LAT; k++) begin
      if (done) early = 1'b1;
      @(negedge clk);
    end
    check(!early, "R5", "done before latency", 32'(early), 32'd0);
    check(done == 1'b1, "R5", "done at latency", 32'(done), 32'd1);
    for (int j = 0; j < 3; j++)
      check(lane_dout[j*W +: W] == ed[j], tag, $sformatf("lane%0d word", j),
            32'(lane_dout[j*W +: W]), 32'(ed[j]));
    check(lane_mismatch == em, "R8", "mismatch flags", 32'(lane_mismatch), 32'(em));
    @(negedge clk);
    check(done == 1'b0, "R5", "done single pulse", 32'(done), 32'd0);
    clear_faults();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    check(lane_dout == '0, "R1", "words after reset", 32'(lane_dout), 32'd0);
    check(lane_mismatch == '0, "R1", "flags after reset", 32'(lane_mismatch), 32'd0);

    // R3: single source, other lanes differ
    mode = 1'b0; src_sel = 2'd0; lane_din = 24'h5A_3C_C3; run("R3");
    mode = 1'b0; src_sel = 2'd3; lane_din = 24'h77_11_22; run("R3");
    // R2: all lanes equal
    mode = 1'b1; lane_din = 24'h9D_9D_9D; run("R2");
    // R4: bitwise majority F0/CC/AA -> E8
    mode = 1'b1; lane_din = 24'hAA_CC_F0; run("R4");
    // R6: source lane 1 sends 11/22/33 to the three relays
    mode = 1'b0; src_sel = 2'd1; lane_din = 24'h00_44_00;
    lane_inj_en = 3'b010; lane_inj_val = '0;
    lane_inj_val[(3+0)*W +: W] = 8'h11; lane_inj_val[(3+1)*W +: W] = 8'h22;
    lane_inj_val[(3+2)*W +: W] = 8'h33;
    run("R6");
    // R7: relay 1 sends a different word to each lane
    mode = 1'b0; src_sel = 2'd0; lane_din = 24'h00_00_6E;
    relay_inj_en = 3'b010; relay_inj_val = 72'h0;
    relay_inj_val[(3+0)*W +: W] = 8'hFF; relay_inj_val[(3+1)*W +: W] = 8'h01;
    relay_inj_val[(3+2)*W +: W] = 8'h80;
    run("R7");
    // R7 in all-source mode with consistent lanes
    mode = 1'b1; lane_din = 24'h42_42_42;
    relay_inj_en = 3'b100; relay_inj_val = 72'({$urandom, $urandom, $urandom});
    run("R7");
    // R9: lane 2 inconsistent in all-source mode
    mode = 1'b1; lane_din = 24'h00_B1_B1;
    lane_inj_en = 3'b100; lane_inj_val = 72'({$urandom, $urandom, $urandom});
    run("R9");
    // R10: result follows values held at start, not the scrambled ones after it
    mode = 1'b0; src_sel = 2'd2; lane_din = 24'hE4_00_00; run("R10");

    for (int n = 0; n < 300; n++) begin
      int    sc;
      string tg;
      mode = 1'($urandom); src_sel = 2'($urandom); lane_din = 24'($urandom);
      clear_faults();
      sc = int'($urandom % 3);
      if (sc == 1) begin
        lane_inj_en = 3'b001 << ($urandom % 3);
        lane_inj_val = 72'({$urandom, $urandom, $urandom});
        tg = mode ? "R9" : "R6";
      end else if (sc == 2) begin
        relay_inj_en = 3'b001 << ($urandom % 3);
        relay_inj_val = 72'({$urandom, $urandom, $urandom});
        tg = "R7";
      end else begin
        tg = mode ? "R4" : "R3";
      end
      run(tg);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule